// File: doc/BRIEF.md
# Host-to-Processor Mailbox with Ownership Flags

This block is a sixteen-byte shared buffer that sits between an external host and a local processor. The host reaches it over a plain strobe-based I/O port. The local processor uses a register bus of the same shape. Each side can read and write every byte. A small set of flags tracks two things: which side has started filling the buffer, and whether a completed message is waiting on either side.

Writing byte 0 marks the start of a message and claims ownership for the writer. The claim succeeds only if the other side holds no claim at that moment. Byte 15 closes a message. A host write to it tells the processor that input is waiting. A processor write to it tells the host that output is waiting. When the receiving side reads byte 15, it consumes the message and clears the matching flags. Input-waiting raises an interrupt to the processor when that interrupt is enabled.

All reads return data combinationally from the current state. Every flag change lands on the clock edge that completes the access.

Top module: `mbx_mailbox`

## Requirements
- R1: After synchronous reset, all sixteen bytes read 0, all flags are 0, the interrupt enable is 0 and `irq` is 0.
- R2: A byte written at index 0..15 from either port can be read back from both ports at the same index. If both ports write the same byte in one cycle, the host value is stored.
- R3: The input-full flag (status bit 7) sets when the host writes byte 15, and clears when the processor reads byte 15. If both happen in the same cycle, the flag ends up set.
- R4: The output-full flag (status bit 6) sets when the processor writes byte 15, and clears when the host reads byte 15. If both happen in the same cycle, the flag ends up set.
- R5: A processor write to the status register (address 16) with bit 6 at 0 clears the output-full flag. Bit 6 at 1 leaves it unchanged. Status bits 7, 5 and 4 are never altered by such a write.
- R6: The host ownership flag (status bit 5) sets when the host writes byte 0 while the processor ownership flag is 0. It clears when the processor reads byte 15.
- R7: The processor ownership flag (status bit 4) sets when the processor writes byte 0 while the host ownership flag is 0. It clears when the host reads byte 15.
- R8: If both ports write byte 0 in the same cycle while neither owns the buffer, the host gains ownership and the processor ownership flag stays 0. The two ownership flags are never both 1.
- R9: `irq` is 1 exactly when the input-full flag and the interrupt enable are both 1. The enable is bit 0 of processor address 17.
- R10: The host reads the status register at address 16 with the same bit layout. Host writes to addresses 16 and 17 change neither the flags nor the interrupt enable.
- R11: A read returns the state from before the clock edge that completes it. A flag change caused by an access is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_addr | input | 5 | Host address: 0..15 bytes, 16 status |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data |
| slv_wr | input | 1 | Processor write strobe |
| slv_rd | input | 1 | Processor read strobe |
| slv_addr | input | 5 | Processor address: 0..15 bytes, 16 status, 17 control |
| slv_wdata | input | 8 | Processor write data |
| slv_rdata | output | 8 | Processor read data |
| irq | output | 1 | Interrupt to the processor |

## Verification
The two ports are independent, so one port can set a flag in the same cycle the other port clears it. Three collisions are driven on purpose:
- A host write of byte 15 against a processor read of byte 15.
- A processor write of byte 15 against a host read of byte 15.
- Byte 0 written by both ports while neither owns the buffer.

Each collision is judged by reading the status register in the following cycle. The expected outcome is the set-over-clear and host-first rules. The read data returned during the collision cycle must be the value from before that cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_DATA_W    = 8;
    localparam int MBX_NUM_BYTES = 16;

    // status bit positions
    localparam int STAT_IN_FULL  = 7;
    localparam int STAT_OUT_FULL = 6;
    localparam int STAT_HST_OWN  = 5;
    localparam int STAT_SLV_OWN  = 4;

    typedef struct packed {
        logic in_full;
        logic out_full;
        logic hst_own;
        logic slv_own;
    } mbx_flags_t;

    typedef struct packed {
        logic wr_byte;
        logic wr_first;
        logic wr_last;
        logic rd_last;
        logic wr_stat;
        logic wr_ctrl;
    } mbx_evt_t;

    typedef enum logic [1:0] {
        SEL_BYTE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } mbx_sel_e;

    function automatic logic [7:0] f_status(input mbx_flags_t f);
        logic [7:0] s;
        s = 8'h00;
        s[STAT_IN_FULL]  = f.in_full;
        s[STAT_OUT_FULL] = f.out_full;
        s[STAT_HST_OWN]  = f.hst_own;
        s[STAT_SLV_OWN]  = f.slv_own;
        return s;
    endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter int NUM_BYTES = MBX_NUM_BYTES,
    parameter int ADDR_W    = $clog2(NUM_BYTES + 2),
    parameter bit HAS_CTRL  = 1'b1
) (
    input  logic                         wr,
    input  logic                         rd,
    input  logic [ADDR_W-1:0]            addr,
    output mbx_evt_t                     evt,
    output mbx_sel_e                     sel,
    output logic [$clog2(NUM_BYTES)-1:0] idx
);
    localparam int IDX_W = $clog2(NUM_BYTES);
    localparam int A_STAT = NUM_BYTES;
    localparam int A_CTRL = NUM_BYTES + 1;

    always_comb begin
        if (int'(addr) < NUM_BYTES)   sel = SEL_BYTE;
        else if (int'(addr) == A_STAT) sel = SEL_STAT;
        else if (HAS_CTRL && int'(addr) == A_CTRL) sel = SEL_CTRL;
        else                           sel = SEL_NONE;
    end

    assign idx = IDX_W'(addr);

    always_comb begin
        evt          = '0;
        evt.wr_byte  = wr && (sel == SEL_BYTE);
        evt.wr_first = evt.wr_byte && (int'(idx) == 0);
        evt.wr_last  = evt.wr_byte && (int'(idx) == NUM_BYTES - 1);
        evt.rd_last  = rd && (sel == SEL_BYTE) && (int'(idx) == NUM_BYTES - 1);
        evt.wr_stat  = wr && (sel == SEL_STAT);
        evt.wr_ctrl  = wr && (sel == SEL_CTRL);
    end

endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int DATA_W    = MBX_DATA_W,
    parameter int NUM_BYTES = MBX_NUM_BYTES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          h_we,
    input  logic [$clog2(NUM_BYTES)-1:0]  h_idx,
    input  logic [DATA_W-1:0]             h_wdata,
    input  logic                          s_we,
    input  logic [$clog2(NUM_BYTES)-1:0]  s_idx,
    input  logic [DATA_W-1:0]             s_wdata,
    output logic [NUM_BYTES*DATA_W-1:0]   mem_flat
);
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (h_we && int'(h_idx) == i)
                q <= h_wdata;      // host wins a same-byte collision
            else if (s_we && int'(s_idx) == i)
                q <= s_wdata;
        end
        assign mem_flat[i*DATA_W +: DATA_W] = q;
    end

endmodule

// File: rtl/mbx_flag_ctl.sv
module mbx_flag_ctl
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       h_wr_first,
    input  logic       h_wr_last,
    input  logic       h_rd_last,
    input  logic       s_wr_first,
    input  logic       s_wr_last,
    input  logic       s_rd_last,
    input  logic       s_obf_clr,
    output mbx_flags_t flags
);
    mbx_flags_t q, n;
    logic h_claim, s_claim;

    always_comb begin
        h_claim = h_wr_first && !q.slv_own;
        s_claim = s_wr_first && !q.hst_own && !h_claim;

        n = q;
        // sets take priority over clears from the other port
        if (h_wr_last)       n.in_full = 1'b1;
        else if (s_rd_last)  n.in_full = 1'b0;

        if (s_wr_last)                    n.out_full = 1'b1;
        else if (h_rd_last || s_obf_clr)  n.out_full = 1'b0;

        if (h_claim)         n.hst_own = 1'b1;
        else if (s_rd_last)  n.hst_own = 1'b0;

        if (s_claim)         n.slv_own = 1'b1;
        else if (h_rd_last)  n.slv_own = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign flags = q;

endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W    = MBX_DATA_W,
    parameter int NUM_BYTES = MBX_NUM_BYTES,
    parameter int ADDR_W    = $clog2(NUM_BYTES + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    input  logic              slv_wr,
    input  logic              slv_rd,
    input  logic [ADDR_W-1:0] slv_addr,
    input  logic [DATA_W-1:0] slv_wdata,
    output logic [DATA_W-1:0] slv_rdata,
    output logic              irq
);
    localparam int IDX_W = $clog2(NUM_BYTES);

    mbx_evt_t   h_evt, s_evt;
    mbx_sel_e   h_sel, s_sel;
    logic [IDX_W-1:0] h_idx, s_idx;
    logic [NUM_BYTES*DATA_W-1:0] mem_flat;
    mbx_flags_t flags;
    logic       irq_en;
    logic [7:0] stat_b;

    mbx_port_dec #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .HAS_CTRL(1'b0)) u_hdec (
        .wr(hst_wr), .rd(hst_rd), .addr(hst_addr),
        .evt(h_evt), .sel(h_sel), .idx(h_idx)
    );

    mbx_port_dec #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .HAS_CTRL(1'b1)) u_sdec (
        .wr(slv_wr), .rd(slv_rd), .addr(slv_addr),
        .evt(s_evt), .sel(s_sel), .idx(s_idx)
    );

    mbx_store #(.DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_store (
        .clk(clk), .rst(rst),
        .h_we(h_evt.wr_byte), .h_idx(h_idx), .h_wdata(hst_wdata),
        .s_we(s_evt.wr_byte), .s_idx(s_idx), .s_wdata(slv_wdata),
        .mem_flat(mem_flat)
    );

    mbx_flag_ctl u_flags (
        .clk(clk), .rst(rst),
        .h_wr_first(h_evt.wr_first), .h_wr_last(h_evt.wr_last), .h_rd_last(h_evt.rd_last),
        .s_wr_first(s_evt.wr_first), .s_wr_last(s_evt.wr_last), .s_rd_last(s_evt.rd_last),
        .s_obf_clr(s_evt.wr_stat && !slv_wdata[STAT_OUT_FULL]),
        .flags(flags)
    );

    always_ff @(posedge clk) begin
        if (rst)               irq_en <= 1'b0;
        else if (s_evt.wr_ctrl) irq_en <= slv_wdata[0];
    end

    assign stat_b = f_status(flags);

    always_comb begin
        case (h_sel)
            SEL_BYTE: hst_rdata = mem_flat[int'(h_idx)*DATA_W +: DATA_W];
            SEL_STAT: hst_rdata = DATA_W'(stat_b);
            default:  hst_rdata = '0;
        endcase
    end

    always_comb begin
        case (s_sel)
            SEL_BYTE: slv_rdata = mem_flat[int'(s_idx)*DATA_W +: DATA_W];
            SEL_STAT: slv_rdata = DATA_W'(stat_b);
            SEL_CTRL: slv_rdata = DATA_W'(irq_en);
            default:  slv_rdata = '0;
        endcase
    end

    assign irq = flags.in_full && irq_en;

endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk
    import mbx_pkg::*;
#(
    parameter int DATA_W = MBX_DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              slv_wr,
    input logic              slv_rd,
    input logic [DATA_W-1:0] slv_wdata,
    input mbx_evt_t          h_evt,
    input mbx_evt_t          s_evt,
    input mbx_flags_t        flags,
    input logic              irq_en,
    input logic              irq
);
    p_in_set_r3: assert property (@(posedge clk) disable iff (rst)
        h_evt.wr_last |=> flags.in_full);

    p_in_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (s_evt.rd_last && !h_evt.wr_last) |=> !flags.in_full);

    p_out_set_r4: assert property (@(posedge clk) disable iff (rst)
        s_evt.wr_last |=> flags.out_full);

    p_out_hclr_r4: assert property (@(posedge clk) disable iff (rst)
        (h_evt.rd_last && !s_evt.wr_last) |=> !flags.out_full);

    p_out_sclr_r5: assert property (@(posedge clk) disable iff (rst)
        (s_evt.wr_stat && !slv_wdata[STAT_OUT_FULL]) |=> !flags.out_full);

    p_stat_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (s_evt.wr_stat && !h_evt.wr_first && !h_evt.wr_last && !h_evt.rd_last)
        |=> ($stable(flags.in_full) && $stable(flags.hst_own) && $stable(flags.slv_own)));

    p_hown_set_r6: assert property (@(posedge clk) disable iff (rst)
        (h_evt.wr_first && !flags.slv_own) |=> flags.hst_own);

    p_sown_set_r7: assert property (@(posedge clk) disable iff (rst)
        (s_evt.wr_first && !flags.hst_own && !h_evt.wr_first) |=> flags.slv_own);

    p_race_r8: assert property (@(posedge clk) disable iff (rst)
        (h_evt.wr_first && s_evt.wr_first && !flags.hst_own && !flags.slv_own)
        |=> (flags.hst_own && !flags.slv_own));

    p_own_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(flags.hst_own && flags.slv_own));

    p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags.in_full && irq_en));

    p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
        (flags.in_full && irq_en) |-> irq);

    p_host_ro_r10: assert property (@(posedge clk) disable iff (rst)
        ((h_evt.wr_stat || h_evt.wr_ctrl) && !slv_wr && !slv_rd)
        |=> ($stable(flags) && $stable(irq_en)));

endmodule

bind mbx_mailbox mbx_mailbox_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .slv_wr(slv_wr), .slv_rd(slv_rd), .slv_wdata(slv_wdata),
    .h_evt(h_evt), .s_evt(s_evt), .flags(flags), .irq_en(irq_en), .irq(irq)
);

// File: tb/mbx_mailbox_tb.sv
module mbx_mailbox_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hst_wr = 0, hst_rd = 0;
    logic [4:0] hst_addr = '0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;
    logic       slv_wr = 0, slv_rd = 0;
    logic [4:0] slv_addr = '0;
    logic [7:0] slv_wdata = '0;
    logic [7:0] slv_rdata;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;   // 125 MHz

    mbx_mailbox dut_i (
        .clk(clk), .rst(rst),
        .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .slv_wr(slv_wr), .slv_rd(slv_rd), .slv_addr(slv_addr),
        .slv_wdata(slv_wdata), .slv_rdata(slv_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one cycle on both ports; read data sampled before the completing edge
    task automatic cyc(input logic hw, input logic hr, input int ha, input int hd,
                       input logic sw, input logic sr, input int sa, input int sd,
                       output logic [7:0] hrd, output logic [7:0] srd);
        @(negedge clk);
        hst_wr = hw; hst_rd = hr; hst_addr = 5'(ha); hst_wdata = 8'(hd);
        slv_wr = sw; slv_rd = sr; slv_addr = 5'(sa); slv_wdata = 8'(sd);
        #1;
        hrd = hst_rdata; srd = slv_rdata;
        @(negedge clk);
        hst_wr = 0; hst_rd = 0; slv_wr = 0; slv_rd = 0;
    endtask

    task automatic h_write(input int a, input int d);
        logic [7:0] x, y;
        cyc(1, 0, a, d, 0, 0, 0, 0, x, y);
    endtask
    task automatic h_read(input int a, output logic [7:0] d);
        logic [7:0] y;
        cyc(0, 1, a, 0, 0, 0, 0, 0, d, y);
    endtask
    task automatic s_write(input int a, input int d);
        logic [7:0] x, y;
        cyc(0, 0, 0, 0, 1, 0, a, d, x, y);
    endtask
    task automatic s_read(input int a, output logic [7:0] d);
        logic [7:0] x;
        cyc(0, 0, 0, 0, 0, 1, a, 0, x, d);
    endtask
    task automatic stat_is(input string req, input logic [7:0] exp);
        logic [7:0] v;
        s_read(16, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        stat_is("R1 status after reset", 8'h00);
        h_read(5, v);  check("R1 byte5 after reset", v, 8'h00);
        s_read(17, v); check("R1 enable after reset", v, 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_data;
        logic [7:0] v, x, y;
        h_write(3, 8'hA5);
        s_read(3, v);  check("R2 host->proc byte3", v, 8'hA5);
        s_write(9, 8'h3C);
        h_read(9, v);  check("R2 proc->host byte9", v, 8'h3C);
        cyc(1, 0, 7, 8'h11, 1, 0, 7, 8'h22, x, y);
        h_read(7, v);  check("R2 collision host view", v, 8'h11);
        s_read(7, v);  check("R2 collision proc view", v, 8'h11);
        stat_is("R2 no flags from middle bytes", 8'h00);
    endtask

    task automatic t_in_full;
        logic [7:0] v;
        s_write(17, 1);
        h_write(15, 8'h77);
        stat_is("R3 in-full set", 8'h80);
        check("R9 irq with enable", {7'b0, irq}, 8'h01);
        s_read(15, v); check("R3 byte15 data", v, 8'h77);
        stat_is("R3 in-full cleared", 8'h00);
        check("R9 irq drops", {7'b0, irq}, 8'h00);
        s_write(17, 0);
        h_write(15, 8'h78);
        check("R9 irq masked", {7'b0, irq}, 8'h00);
        stat_is("R9 flag still set when masked", 8'h80);
        s_read(15, v);
    endtask

    task automatic t_out_full;
        logic [7:0] v;
        s_write(15, 8'h5A);
        stat_is("R4 out-full set", 8'h40);
        h_read(15, v); check("R4 host reads byte15", v, 8'h5A);
        stat_is("R4 out-full cleared", 8'h00);
        s_write(15, 8'h5B);
        s_write(16, 8'hFF);
        stat_is("R5 bit6=1 keeps out-full", 8'h40);
        s_write(16, 8'h00);
        stat_is("R5 bit6=0 clears out-full", 8'h00);
        h_write(0, 8'h01);
        h_write(15, 8'h02);
        s_write(16, 8'h00);
        stat_is("R5 other bits untouched", 8'hA0);
        s_read(15, v);
        stat_is("R6 proc read of byte15 releases", 8'h00);
    endtask

    task automatic t_own;
        logic [7:0] v;
        h_write(0, 8'h10);
        stat_is("R6 host claims", 8'h20);
        s_write(0, 8'h20);
        stat_is("R7 proc claim refused", 8'h20);
        s_read(15, v);
        stat_is("R6 release", 8'h00);
        s_write(0, 8'h30);
        stat_is("R7 proc claims", 8'h10);
        h_write(0, 8'h40);
        stat_is("R6 host claim refused", 8'h10);
        h_read(15, v);
        stat_is("R7 host read releases", 8'h00);
    endtask

    task automatic t_race;
        logic [7:0] v, x, y;
        cyc(1, 0, 0, 8'hC1, 1, 0, 0, 8'hC2, x, y);
        stat_is("R8 host wins byte0 race", 8'h20);
        h_read(0, v);  check("R8 byte0 holds host value", v, 8'hC1);
        s_read(15, v);
        h_write(15, 8'h61);
        cyc(1, 0, 15, 8'h62, 0, 1, 15, 0, x, y);
        check("R11 proc read sees old byte15", y, 8'h61);
        stat_is("R3 set beats clear", 8'h80);
        s_read(15, v);
        s_write(15, 8'h71);
        cyc(0, 1, 15, 0, 1, 0, 15, 8'h72, x, y);
        check("R11 host read sees old byte15", x, 8'h71);
        stat_is("R4 set beats clear", 8'h40);
        h_read(15, v);
        stat_is("R4 cleared after race", 8'h00);
    endtask

    task automatic t_timing;
        logic [7:0] v, x, y;
        cyc(1, 0, 15, 8'h99, 0, 1, 16, 0, x, y);
        check("R11 status pre-edge", y, 8'h00);
        stat_is("R11 status next cycle", 8'h80);
        s_read(15, v);
    endtask

    task automatic t_host_stat;
        logic [7:0] v;
        h_write(0, 8'h05);
        h_read(16, v); check("R10 host status layout", v, 8'h20);
        h_write(16, 8'h00);
        stat_is("R10 host status write ignored", 8'h20);
        h_write(17, 8'h01);
        s_read(17, v); check("R10 host ctrl write ignored", v, 8'h00);
        h_read(17, v); check("R10 host ctrl reads zero", v, 8'h00);
        s_read(15, v);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_data;
        t_in_full;
        t_out_full;
        t_own;
        t_race;
        t_timing;
        t_host_stat;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule